// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synchronous static memory whose command inputs are registered on the rising clock edge and whose read data flows from the array to the output pins in the cycle right after the command edge. Reads and writes may follow each other on consecutive edges with no idle cycles. A write command is sampled on one edge and its data is sampled on the next enabled edge. That data then sits in a one-entry pending register and reaches the array only when the following write's data arrives. A read that hits the pending address sees the pending bytes merged over the array contents.

An active-low clock enable freezes every register, so the previous cycle is extended. The three chip selects are decoded together. An advance/load control either loads a fresh command or repeats the previous one at the next address of a four-word linear burst. The output-drive flag follows an asynchronous active-low output enable. The flag is forced off during write-data cycles, while deselected and in the first cycle after a deselected cycle. The array depth is a parameter and stays small for simulation. The data bus is split into separate input, output and drive-flag ports, so an enclosing pad ring can build the tri-state pin from them.

Top module: `zt_sram`

## Requirements
- R1: When `ce_n` is high at a rising edge, no register, pending write or array word changes, and `d_out` holds its value through the next cycle.
- R2: A load (`adv_ld`=0) selects the memory only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Any other combination loads an idle cycle in which `d_oe` is 0.
- R3: Lane l is bits [8l+7:8l] of the word. With `lane_n[l]`=0 on a write command, that byte is written. With `lane_n[l]`=1, the stored byte is kept and the input byte is ignored.
- R4: In the cycle after an enabled edge that loads a read at address A, `d_out` equals word A. `d_oe` is 1 if `oe_n` is 0 and neither R5, R6 nor R2 forces drive off.
- R5: Write data is sampled at the first enabled edge after the write command's edge, and `d_oe` is 0 throughout that write-data cycle.
- R6: A command loaded at the edge that ends an idle (deselected) cycle, including the first command after reset, gets `d_oe`=0 in its cycle.
- R7: While `oe_n` is 1, `d_oe` is 0 at once, without waiting for a clock edge.
- R8: A read whose address equals the pending write's address returns, per lane, the pending byte for lanes enabled in that write and the array byte for the rest. This includes a read loaded on the edge that samples that write's data.
- R9: Reset clears the command state to idle with `d_oe`=0 and discards the pending write without committing it. Array contents are kept.
- R10: With `adv_ld`=1 at an enabled edge, the previous operation type is repeated, address bits [1:0] step +1 modulo 4 and upper bits stay. The selects, `wr_n` and `addr` are ignored. The byte enables still apply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Active-low clock enable; high stalls the block |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 1 = advance burst, 0 = load new command |
| wr_n | input | 1 | 0 = write command, 1 = read command |
| lane_n | input | LANES | Active-low byte-lane write enables |
| addr | input | AW | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| d_in | input | DW | Write data bus |
| d_out | output | DW | Read data bus |
| d_oe | output | 1 | Output-drive flag for the data pins |

## Verification
The bench targets a read loaded on the same edge that samples the matching write's data, partial-lane writes that overlap a pending entry, burst wrap from address bits 11 to 00, and stalls placed inside write-data cycles. A design without the bypass would return stale array bytes. A design that commits on the wrong edge would merge the lanes from the wrong write, and a broken burst counter would carry into the upper address bits. It also drives every chip-select combination, the dummy cycle after a deselect, and a reset that lands while a write is pending. Those cases catch drive enabled on a write-data or warm-up cycle, and a pending write that leaks into the array across reset.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/zt_rst_sync.sv
module zt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign srst_n = stg_q[1];
endmodule

// File: rtl/zt_cmd_stage.sv
module zt_cmd_stage
  import zt_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             adv_ld,
  input  logic             wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_n,
  output op_e              op_q,
  output logic [AW-1:0]    addr_q,
  output logic [LANES-1:0] mask_q,
  output logic             warm_q
);
  op_e              op_d;
  logic [AW-1:0]    addr_d;
  logic [AW-1:0]    adv_addr;
  logic [LANES-1:0] mask_d;
  logic             warm_d;
  logic             picked;

  // R10: burst step wraps inside the low two address bits
  if (AW > 2) begin : g_wide
    assign adv_addr = {addr_q[AW-1:2], addr_q[1:0] + 2'd1};
  end else begin : g_narrow
    assign adv_addr = addr_q + 2'd1;
  end

  // R2: all three selects must agree
  assign picked = ~sel0_n & sel1 & ~sel2_n;

  always_comb begin
    op_d   = op_q;
    addr_d = addr_q;
    mask_d = mask_q;
    warm_d = warm_q;
    if (en) begin
      if (adv_ld) begin
        addr_d = adv_addr;
      end else begin
        addr_d = addr;
        if (!picked)    op_d = OP_IDLE;
        else if (wr_n)  op_d = OP_RD;
        else            op_d = OP_WR;
      end
      mask_d = ~lane_n;
      // R6: remember that the cycle being left was idle
      warm_d = (op_q == OP_IDLE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      mask_q <= '0;
      warm_q <= 1'b1;
    end else begin
      op_q   <= op_d;
      addr_q <= addr_d;
      mask_q <= mask_d;
      warm_q <= warm_d;
    end
  end
endmodule

// File: rtl/zt_wr_queue.sv
module zt_wr_queue
  import zt_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 5,
  parameter int DW    = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  op_e              op_q,
  input  logic [AW-1:0]    addr_q,
  input  logic [LANES-1:0] mask_q,
  input  logic [DW-1:0]    d_in,
  output logic             pend_v,
  output logic [AW-1:0]    pend_addr,
  output logic [LANES-1:0] pend_mask,
  output logic [DW-1:0]    pend_data,
  output logic             cmt_en
);
  logic             take;
  logic             pend_v_d;
  logic [AW-1:0]    pend_addr_d;
  logic [LANES-1:0] pend_mask_d;
  logic [DW-1:0]    pend_data_d;

  // R5: data is taken on the enabled edge that ends a write-data cycle
  assign take   = en & (op_q == OP_WR);
  // the older entry retires as the newer one arrives
  assign cmt_en = take & pend_v;

  always_comb begin
    pend_v_d    = pend_v;
    pend_addr_d = pend_addr;
    pend_mask_d = pend_mask;
    pend_data_d = pend_data;
    if (take) begin
      pend_v_d    = 1'b1;
      pend_addr_d = addr_q;
      pend_mask_d = mask_q;
      pend_data_d = d_in;
    end
  end

  // R9: reset discards the entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_mask <= '0;
      pend_data <= '0;
    end else begin
      pend_v    <= pend_v_d;
      pend_addr <= pend_addr_d;
      pend_mask <= pend_mask_d;
      pend_data <= pend_data_d;
    end
  end
endmodule

// File: rtl/zt_array.sv
module zt_array #(
  parameter int DEPTH  = 64,
  parameter int AW     = 6,
  parameter int LANES  = 5,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             cmt_en,
  input  logic [AW-1:0]    cmt_addr,
  input  logic [LANES-1:0] cmt_mask,
  input  logic [DW-1:0]    cmt_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic             pend_v,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] raw;
  logic          hit;

  // R3: only enabled lanes are stored
  always_ff @(posedge clk) begin
    if (cmt_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (cmt_mask[l]) mem[cmt_addr][l*LANE_W +: LANE_W] <= cmt_data[l*LANE_W +: LANE_W];
      end
    end
  end

  assign raw = mem[rd_addr];
  assign hit = pend_v & (cmt_addr == rd_addr);

  // R8: per-lane merge of the pending entry over the array word
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_data[g*LANE_W +: LANE_W] = (hit & cmt_mask[g]) ? cmt_data[g*LANE_W +: LANE_W]
                                                            : raw[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LANES  = 5,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             adv_ld,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_n,
  input  logic [AW-1:0]    addr,
  input  logic             oe_n,
  input  logic [DW-1:0]    d_in,
  output logic [DW-1:0]    d_out,
  output logic             d_oe
);
  logic             srst_n;
  logic             en;
  op_e              op_q;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] mask_q;
  logic             warm_q;
  logic             pend_v;
  logic [AW-1:0]    pend_addr;
  logic [LANES-1:0] pend_mask;
  logic [DW-1:0]    pend_data;
  logic             cmt_en;

  // R1: a high clock enable freezes every stage
  assign en = ~ce_n;

  zt_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  zt_cmd_stage #(.AW(AW), .LANES(LANES)) u_cmd (
    .clk    (clk),
    .rst_n  (srst_n),
    .en     (en),
    .sel0_n (sel0_n),
    .sel1   (sel1),
    .sel2_n (sel2_n),
    .adv_ld (adv_ld),
    .wr_n   (wr_n),
    .addr   (addr),
    .lane_n (lane_n),
    .op_q   (op_q),
    .addr_q (addr_q),
    .mask_q (mask_q),
    .warm_q (warm_q)
  );

  zt_wr_queue #(.AW(AW), .LANES(LANES), .DW(DW)) u_wq (
    .clk       (clk),
    .rst_n     (srst_n),
    .en        (en),
    .op_q      (op_q),
    .addr_q    (addr_q),
    .mask_q    (mask_q),
    .d_in      (d_in),
    .pend_v    (pend_v),
    .pend_addr (pend_addr),
    .pend_mask (pend_mask),
    .pend_data (pend_data),
    .cmt_en    (cmt_en)
  );

  zt_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk      (clk),
    .cmt_en   (cmt_en),
    .cmt_addr (pend_addr),
    .cmt_mask (pend_mask),
    .cmt_data (pend_data),
    .rd_addr  (addr_q),
    .pend_v   (pend_v),
    .rd_data  (d_out)
  );

  // R4 R5 R6 R7: drive only on a warmed-up read with the output enable low
  assign d_oe = (op_q == OP_RD) & ~warm_q & ~oe_n;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
  import zt_sram_pkg::*;
#(
  parameter int DW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          adv_ld,
  input logic          sel0_n,
  input logic          sel1,
  input logic          sel2_n,
  input logic          oe_n,
  input logic          d_oe,
  input logic [DW-1:0] d_out,
  input op_e           op_q,
  input logic          pend_v
);
  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> $stable(d_out));

  // R2
  desel_drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !adv_ld && !(!sel0_n && sel1 && !sel2_n)) |=> !d_oe);

  // R5
  wr_data_drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_WR) |-> !d_oe);

  // R5
  wr_data_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && op_q == OP_WR) |=> pend_v);

  // R6
  warm_up_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !adv_ld && op_q == OP_IDLE) |=> !d_oe);

  // R7
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !d_oe);
endmodule

bind zt_sram zt_sram_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ce_n   (ce_n),
  .adv_ld (adv_ld),
  .sel0_n (sel0_n),
  .sel1   (sel1),
  .sel2_n (sel2_n),
  .oe_n   (oe_n),
  .d_oe   (d_oe),
  .d_out  (d_out),
  .op_q   (op_q),
  .pend_v (pend_v)
);

// File: tb/zt_sram_tb.sv
module zt_sram_tb;
  localparam int DEPTH = 64;
  localparam int LANES = 5;
  localparam int AW    = 6;
  localparam int DW    = 40;

  logic clk = 1'b0;
  logic rst_n, ce_n, sel0_n, sel1, sel2_n, adv_ld, wr_n, oe_n, d_oe;
  logic [LANES-1:0] lane_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] d_in, d_out;

  always #2 clk = ~clk;

  zt_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .adv_ld(adv_ld), .wr_n(wr_n), .lane_n(lane_n), .addr(addr),
    .oe_n(oe_n), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural reference: op 0 idle, 1 read, 2 write
  int m_op;
  int unsigned m_addr;
  logic [4:0] m_mask;
  bit m_warm;
  logic [7:0] mem_b [DEPTH][LANES];
  int unsigned q_addr[$];
  logic [DW-1:0] q_data[$];
  logic [4:0] q_mask[$];
  string phase_tag = "R4";
  bit stalled_last = 1'b0;
  logic [DW-1:0] last_dout;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_word();
    logic [DW-1:0] w;
    for (int l = 0; l < LANES; l++) begin
      if (q_addr.size() != 0 && q_addr[0] == m_addr && q_mask[0][l]) w[l*8 +: 8] = q_data[0][l*8 +: 8];
      else w[l*8 +: 8] = mem_b[m_addr][l];
    end
    return w;
  endfunction

  function automatic logic [DW-1:0] pattern(input int i);
    return 40'h13_5724_68AC * (i + 3) ^ {i[7:0], 32'h0};
  endfunction

  task automatic model_reset();
    m_op = 0; m_addr = 0; m_mask = '0; m_warm = 1'b1;
    q_addr.delete(); q_data.delete(); q_mask.delete();
  endtask

  task automatic model_edge(input logic adv, s0, s1, s2, wrn, input logic [AW-1:0] a,
                            input logic [4:0] ln, input logic [DW-1:0] din);
    int old_op = m_op;
    if (m_op == 2) begin
      if (q_addr.size() != 0) begin
        for (int l = 0; l < LANES; l++)
          if (q_mask[0][l]) mem_b[q_addr[0]][l] = q_data[0][l*8 +: 8];
        void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_mask.pop_front());
      end
      q_addr.push_back(m_addr); q_data.push_back(din); q_mask.push_back(m_mask);
    end
    if (!adv) begin
      m_op = (!s0 && s1 && !s2) ? (wrn ? 1 : 2) : 0;
      m_addr = a;
    end else begin
      m_addr = (m_addr & ~32'd3) | ((m_addr + 1) & 32'd3);
    end
    m_mask = ~ln;
    m_warm = (old_op == 0);
  endtask

  task automatic step(input logic ce, adv, s0, s1, s2, wrn, input logic [AW-1:0] a,
                      input logic [4:0] ln, input logic oe, input logic [DW-1:0] din);
    logic exp_oe;
    string t;
    @(negedge clk);
    ce_n = ce; adv_ld = adv; sel0_n = s0; sel1 = s1; sel2_n = s2; wr_n = wrn;
    addr = a; lane_n = ln; oe_n = oe; d_in = din;
    #1;
    exp_oe = (m_op == 1) && !m_warm && !oe;
    if (m_op == 2) t = "R5";
    else if (m_op == 0) t = "R2";
    else if (m_warm) t = "R6";
    else if (oe) t = "R7";
    else t = "R4";
    check(d_oe === exp_oe, t, {39'd0, d_oe}, {39'd0, exp_oe});
    if (m_op == 1) begin
      if (q_addr.size() != 0 && q_addr[0] == m_addr) t = "R8";
      else t = phase_tag;
      check(d_out === exp_word(), t, d_out, exp_word());
    end
    if (stalled_last) check(d_out === last_dout, "R1", d_out, last_dout);
    last_dout = d_out;
    @(posedge clk);
    if (!ce) model_edge(adv, s0, s1, s2, wrn, a, ln, din);
    stalled_last = ce;
  endtask

  // shorthands: load read / load write / idle load / advance
  task automatic rd(input int a, input logic [DW-1:0] din = '0);
    step(0, 0, 0, 1, 0, 1, a[AW-1:0], 5'h1F, 0, din);
  endtask
  task automatic wr(input int a, input logic [4:0] ln, input logic [DW-1:0] din);
    step(0, 0, 0, 1, 0, 0, a[AW-1:0], ln, 0, din);
  endtask
  task automatic idle(input logic [DW-1:0] din = '0);
    step(0, 0, 1, 1, 0, 1, '0, 5'h1F, 0, din);
  endtask
  task automatic adv(input logic [4:0] ln, input logic [DW-1:0] din);
    step(0, 1, 1, 0, 1, 1, '0, ln, 0, din);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b0;
    model_reset();
    #1;
    // R9: reset forces the drive flag off at once
    check(d_oe === 1'b0, "R9", {39'd0, d_oe}, 40'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    stalled_last = 1'b0;
    repeat (4) step(1, 0, 1, 1, 0, 1, '0, 5'h1F, 0, '0);
    check(d_oe === 1'b0, "R9", {39'd0, d_oe}, 40'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] prev;
    rst_n = 1'b0; ce_n = 1'b1; sel0_n = 1'b1; sel1 = 1'b0; sel2_n = 1'b1;
    adv_ld = 1'b0; wr_n = 1'b1; lane_n = '1; addr = '0; oe_n = 1'b0; d_in = '0;
    model_reset();
    do_reset();

    // fill the array, back-to-back writes (R5)
    phase_tag = "R5";
    prev = '0;
    for (int i = 0; i < DEPTH; i++) begin
      wr(i, 5'h00, prev);
      prev = pattern(i);
    end
    idle(prev);
    idle();

    // back-to-back reads; the first one is a warm-up (R6, R4)
    phase_tag = "R4";
    for (int i = 0; i < DEPTH; i++) rd(i);
    idle();

    // partial write, committed by a later write, then read (R3)
    phase_tag = "R3";
    wr(5, 5'b10101, '0);
    idle(40'hAA_BBCC_DDEE);
    wr(9, 5'h00, '0);
    idle(40'h11_2233_4455);
    rd(0); rd(5); rd(9);
    // read loaded on the data edge of a partial write (R8)
    phase_tag = "R8";
    wr(7, 5'b01010, '0);
    rd(7, 40'h99_8877_6655);
    rd(7); wr(7, 5'b11110, '0); rd(7, 40'hF0_E1D2_C3B4); rd(6); rd(7);
    idle();

    // bursts with wrap (R10): 6,7,4,5,6
    phase_tag = "R10";
    rd(6); adv(5'h1F, '0); adv(5'h1F, '0); adv(5'h1F, '0); adv(5'h1F, '0);
    wr(14, 5'h00, '0); adv(5'h00, 40'h01_0101_0101); adv(5'b00011, 40'h02_0202_0202);
    adv(5'h00, 40'h03_0303_0303); idle(40'h04_0404_0404);
    rd(12); rd(13); rd(14); rd(15); rd(12);
    idle();

    // every select combination (R2)
    for (int c = 0; c < 8; c++) begin
      step(0, 0, c[0], c[1], c[2], 1, 6'd3, 5'h1F, 0, '0);
      rd(3);
    end
    idle();

    // output enable high on a warmed read (R7)
    rd(1); step(0, 0, 0, 1, 0, 1, 6'd2, 5'h1F, 1, '0); rd(3);
    step(0, 0, 0, 1, 0, 1, 6'd4, 5'h1F, 1, '0);

    // stalls with changing inputs, including inside a write-data cycle (R1)
    phase_tag = "R1";
    rd(8);
    step(1, 0, 0, 1, 0, 0, 6'd20, 5'h00, 0, 40'hDE_AD00_BEEF);
    step(1, 1, 1, 0, 1, 0, 6'd21, 5'h00, 0, 40'hDE_AD00_BEEF);
    wr(8, 5'h00, '0);
    step(1, 0, 0, 1, 0, 1, 6'd30, 5'h00, 0, 40'h55_5555_5555);
    rd(8, 40'h12_3456_789A);
    step(1, 0, 1, 1, 1, 1, 6'd0, 5'h00, 0, '0);
    rd(8);

    // random mix biased toward address collisions
    phase_tag = "R4";
    for (int n = 0; n < 3000; n++) begin
      logic c, a, s0, s1, s2, w, o;
      logic [AW-1:0] ad;
      logic [4:0] ln;
      c  = ($urandom % 100) < 15;
      a  = ($urandom % 100) < 25;
      s0 = ($urandom % 100) < 8;
      s1 = ($urandom % 100) >= 8;
      s2 = ($urandom % 100) < 5;
      w  = ($urandom % 2) != 0;
      ad = (($urandom % 2) != 0) ? AW'($urandom % 8) : AW'($urandom);
      ln = (($urandom % 100) < 30) ? 5'($urandom) : 5'h00;
      o  = ($urandom % 100) < 10;
      step(c, a, s0, s1, s2, w, ad, ln, o, {8'($urandom), 32'($urandom)});
    end
    idle(); idle();

    // reset with a write still pending: it must not reach the array (R9)
    phase_tag = "R9";
    wr(40, 5'h00, '0);
    idle(40'hCA_FECA_FECA);
    do_reset();
    rd(40); rd(40); rd(41);
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule